// File: doc/BRIEF.md
# Four-Channel DMA Sequencer with Two-Tier Termination

This block sequences a small four-channel DMA engine. Each channel has a source address, a destination address, a transfer count and a control word with enable, interrupt-enable and end-flag bits. A global register holds a master enable and an emergency-stop flag. One eligible channel at a time is placed on a single-beat request/grant bus. After each beat, that channel's addresses and count are updated.

A channel can end in two ways. When its count runs out, the end flag is set and an end interrupt can be raised. In the other case, a stop comes from the channel enable being cleared, the emergency-stop flag being set, or the master enable being cleared. The channel then goes quiet with no end flag, and its registers keep the values left by the beats already finished. Software reaches the registers through a plain write port and a one-cycle-latency read port.

Top module: `dma_term_ctrl`

## Requirements
- R1: A beat that takes a channel's count from 1 to 0 sets that channel's end flag on the following cycle. That channel then makes no further requests.
- R2: `irq[n]` is high while channel n has both its end flag and its interrupt-enable bit set. It falls once either bit is cleared.
- R3: Clearing a channel's enable bit while its request is pending but not granted withdraws the request one cycle after the write. The end flag stays clear and the count is unchanged.
- R4: A pulse on `nmi_set` sets the stop flag at the next edge. Any pending request is withdrawn one cycle later. No end flag is set, and the count and addresses keep their values.
- R5: Writing the master enable to 0 withdraws any pending request one cycle after the write. No end flag is set, and the counts are kept.
- R6: Each beat (a cycle with `bus_req` and `bus_gnt` both high) adds 4 to the active channel's source and destination addresses and subtracts 1 from its count. The new values are visible on the following cycle.
- R7: When several channels are eligible, the lowest-numbered channel is requested first.
- R8: A channel is eligible only when its enable bit is 1, its end flag is 0, its count is nonzero, the master enable is 1 and the stop flag is 0. A channel enabled with a zero count never requests and never sets its end flag.
- R9: The end flag and the stop flag are cleared by writing 0 to their bit. Writing 1 to either bit leaves it unchanged.
- R10: If `nmi_set` and a software write clearing the stop flag happen in the same cycle, the stop flag ends up set.
- R11: After the stop flag is cleared by software, an eligible channel requests again one cycle after that write.
- R12: The register map uses bit 4 of the register address as the global-register select.
  - With bit 4 at 0, bits 3:2 choose the channel and bits 1:0 choose the field: 0 source, 1 destination, 2 count (16 bits, zero-extended), 3 control.
  - The control word has enable in bit 0, interrupt-enable in bit 1 and the end flag in bit 2.
  - The global register has the master enable in bit 0 and the stop flag in bit 1.
  - `rd_data` shows the register chosen by `rd_addr` one cycle after the address is presented.
- R13: From idle, `bus_req` rises one cycle after a channel becomes eligible. At the same time, `bus_ch`, `bus_src` and `bus_dst` show that channel and its current addresses. `bus_req` falls on the cycle after a beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Registered read data |
| nmi_set | input | 1 | Pulse that sets the stop flag |
| bus_req | output | 1 | Single-beat transfer request |
| bus_gnt | input | 1 | Grant; a beat completes in a cycle where both request and grant are high |
| bus_ch | output | 2 | Channel owning the request |
| bus_src | output | 32 | Source address of the requested beat |
| bus_dst | output | 32 | Destination address of the requested beat |
| irq | output | 4 | Per-channel end interrupt requests |

## Verification
Register writes and beats take effect at the clock edge on which they occur, so the counts, addresses, flags and `irq` are checked on the next falling edge. The request output sits one register further along: after a write that enables, stops or resumes a channel, and after a stop pulse, the bench waits one extra edge before sampling `bus_req` and `bus_ch`. Read data is sampled one cycle after the address is driven. The grant is held low except during a single chosen cycle, so the bench decides exactly where each beat falls and can predict every count and address from that.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  localparam logic [1:0] FLD_SRC  = 2'd0;
  localparam logic [1:0] FLD_DST  = 2'd1;
  localparam logic [1:0] FLD_CNT  = 2'd2;
  localparam logic [1:0] FLD_CTRL = 2'd3;

  localparam int CTL_EN   = 0;
  localparam int CTL_IE   = 1;
  localparam int CTL_DONE = 2;

  localparam int GLB_ME  = 0;
  localparam int GLB_NMI = 1;
endpackage

// File: rtl/dma_term_chan.sv
module dma_term_chan
  import dma_term_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [1:0]    wr_fld,
  input  logic [AW-1:0] wr_data,
  input  logic          beat,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          en_o,
  output logic          ie_o,
  output logic          done_o
);
  // A beat's update is applied after a same-cycle software write, so it wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      src_o  <= '0;
      dst_o  <= '0;
      cnt_o  <= '0;
      en_o   <= 1'b0;
      ie_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      if (wr_hit) begin
        case (wr_fld)
          FLD_SRC: src_o <= wr_data;
          FLD_DST: dst_o <= wr_data;
          FLD_CNT: cnt_o <= wr_data[CW-1:0];
          default: begin
            en_o <= wr_data[CTL_EN];
            ie_o <= wr_data[CTL_IE];
            if (!wr_data[CTL_DONE]) done_o <= 1'b0;
          end
        endcase
      end
      if (beat) begin
        src_o <= src_o + AW'(STEP);
        dst_o <= dst_o + AW'(STEP);
        cnt_o <= cnt_o - CW'(1);
        if (cnt_o == CW'(1)) done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_glob_reg.sv
module dma_glob_reg
  import dma_term_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic [1:0] wr_bits,
  input  logic       nmi_set,
  output logic       me_o,
  output logic       nmi_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      me_o  <= 1'b0;
      nmi_o <= 1'b0;
    end else begin
      if (wr_hit) begin
        me_o <= wr_bits[GLB_ME];
        if (!wr_bits[GLB_NMI]) nmi_o <= 1'b0;
      end
      if (nmi_set) nmi_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dma_term_pkg::*;
#(
  parameter  int NCH  = 4,
  parameter  int AW   = 32,
  parameter  int CW   = 16,
  parameter  int STEP = 4,
  localparam int CHB  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW  = CHB + 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [AW-1:0]  wr_data,
  input  logic [RAW-1:0] rd_addr,
  output logic [AW-1:0]  rd_data,
  input  logic           nmi_set,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic [CHB-1:0] bus_ch,
  output logic [AW-1:0]  bus_src,
  output logic [AW-1:0]  bus_dst,
  output logic [NCH-1:0] irq
);
  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  logic [CW-1:0]  cnt_a [NCH];
  logic [NCH-1:0] en_v, ie_v, done_v, elig, beat_v;
  logic           me_q, nmi_q;
  logic           busy_q;
  logic [CHB-1:0] act_q;
  logic           arb_any;
  logic [CHB-1:0] arb_idx;
  logic [CHB-1:0] rd_ch;

  dma_glob_reg u_glob (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (wr_en && wr_addr[RAW-1]),
    .wr_bits (wr_data[1:0]),
    .nmi_set (nmi_set),
    .me_o    (me_q),
    .nmi_o   (nmi_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_term_chan #(.AW(AW), .CW(CW), .STEP(STEP)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (wr_en && !wr_addr[RAW-1] && (wr_addr[CHB+1:2] == CHB'(i))),
      .wr_fld  (wr_addr[1:0]),
      .wr_data (wr_data),
      .beat    (beat_v[i]),
      .src_o   (src_a[i]),
      .dst_o   (dst_a[i]),
      .cnt_o   (cnt_a[i]),
      .en_o    (en_v[i]),
      .ie_o    (ie_v[i]),
      .done_o  (done_v[i])
    );
    assign elig[i]   = en_v[i] && !done_v[i] && (cnt_a[i] != '0) && me_q && !nmi_q;
    assign beat_v[i] = busy_q && bus_gnt && (act_q == CHB'(i));
  end

  dma_prio_arb #(.N(NCH)) u_arb (
    .req (elig),
    .any (arb_any),
    .idx (arb_idx)
  );

  // Sequencer: a grant seen while requesting completes the beat; otherwise
  // the request is dropped as soon as the owning channel loses eligibility.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      act_q   <= '0;
      bus_src <= '0;
      bus_dst <= '0;
    end else if (busy_q) begin
      if (bus_gnt || !elig[act_q]) busy_q <= 1'b0;
    end else if (arb_any) begin
      busy_q  <= 1'b1;
      act_q   <= arb_idx;
      bus_src <= src_a[arb_idx];
      bus_dst <= dst_a[arb_idx];
    end
  end

  assign bus_req = busy_q;
  assign bus_ch  = act_q;
  assign irq     = done_v & ie_v;

  assign rd_ch = rd_addr[CHB+1:2];
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_addr[RAW-1]) begin
      rd_data <= AW'({nmi_q, me_q});
    end else begin
      case (rd_addr[1:0])
        FLD_SRC: rd_data <= src_a[rd_ch];
        FLD_DST: rd_data <= dst_a[rd_ch];
        FLD_CNT: rd_data <= AW'(cnt_a[rd_ch]);
        default: rd_data <= AW'({done_v[rd_ch], ie_v[rd_ch], en_v[rd_ch]});
      endcase
    end
  end
endmodule

// File: rtl/dma_term_chk.sv
module dma_term_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           nmi_set,
  input logic           nmi_flag,
  input logic           me,
  input logic [NCH-1:0] beat,
  input logic [CW-1:0]  cnt [NCH],
  input logic [NCH-1:0] done
);
  assert_single_beat_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0(beat));

  assert_release_after_beat_R13: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt) |=> !bus_req);

  assert_nmi_halts_R4: assert property (@(posedge clk) disable iff (rst)
    nmi_flag |=> !bus_req);

  assert_master_off_halts_R5: assert property (@(posedge clk) disable iff (rst)
    !me |=> !bus_req);

  assert_nmi_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    nmi_set |=> nmi_flag);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
      beat[i] |=> (cnt[i] == CW'($past(cnt[i]) - CW'(1))));

    assert_exhaust_sets_end_R1: assert property (@(posedge clk) disable iff (rst)
      (beat[i] && cnt[i] == CW'(1)) |=> done[i]);

    assert_end_only_by_beat_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(done[i]) |-> $past(beat[i]));
  end
endmodule

bind dma_term_ctrl dma_term_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .nmi_set  (nmi_set),
  .nmi_flag (nmi_q),
  .me       (me_q),
  .beat     (beat_v),
  .cnt      (cnt_a),
  .done     (done_v)
);

// File: tb/tb_dma_term_ctrl.sv
module tb_dma_term_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [68:0] VEC [NV] = '{
    {5'd0,  32'h1000_0000, 32'h1000_0000},
    {5'd5,  32'hABCD_0004, 32'hABCD_0004},
    {5'd14, 32'h0001_0005, 32'h0000_0005},
    {5'd11, 32'h0000_0003, 32'h0000_0003},
    {5'd11, 32'h0000_0007, 32'h0000_0003},
    {5'd15, 32'hFFFF_FFFA, 32'h0000_0002},
    {5'd16, 32'h0000_0002, 32'h0000_0000},
    {5'd8,  32'h0000_0FFC, 32'h0000_0FFC}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        nmi_set = 1'b0;
  logic        bus_req;
  logic        bus_gnt = 1'b0;
  logic [1:0]  bus_ch;
  logic [31:0] bus_src, bus_dst;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_term_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .nmi_set(nmi_set), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_ch(bus_ch), .bus_src(bus_src), .bus_dst(bus_dst), .irq(irq)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic beat_once();
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // reset state
    chk(bus_req == 1'b0, "R13 reset bus_req", 32'(bus_req), 0);
    chk(irq == 4'b0, "R2 reset irq", 32'(irq), 0);
    rd(5'd16, v); chk(v == 0, "R12 reset global", v, 0);
    rd(5'd7, v);  chk(v == 0, "R12 reset ctrl", v, 0);

    // register table walk (master enable stays off)
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][68:64], VEC[k][63:32]);
      rd(VEC[k][68:64], v);
      chk(v == VEC[k][31:0], (k == 4 || k == 6) ? "R9 write-one ignored" : "R12 readback",
          v, VEC[k][31:0]);
    end

    do_reset();
    // two channels, priority and count exhaustion
    wr(5'd4, 32'h100); wr(5'd5, 32'h800); wr(5'd6, 32'd2); wr(5'd7, 32'd3);
    wr(5'd8, 32'h200); wr(5'd9, 32'h900); wr(5'd10, 32'd2); wr(5'd11, 32'd1);
    wr(5'd16, 32'd1);
    @(negedge clk);
    chk(bus_req == 1'b1, "R13 request rises", 32'(bus_req), 1);
    chk(bus_ch == 2'd1, "R7 lowest channel first", 32'(bus_ch), 1);
    chk(bus_src == 32'h100 && bus_dst == 32'h800, "R13 beat addresses", bus_src, 32'h100);
    beat_once();
    chk(bus_req == 1'b0, "R13 release after beat", 32'(bus_req), 0);
    rd(5'd4, v); chk(v == 32'h104, "R6 source step", v, 32'h104);
    rd(5'd5, v); chk(v == 32'h804, "R6 destination step", v, 32'h804);
    rd(5'd6, v); chk(v == 32'd1, "R6 count step", v, 1);
    chk(bus_req && bus_ch == 2'd1 && bus_src == 32'h104, "R7 same channel again", bus_src, 32'h104);
    beat_once();
    rd(5'd7, v); chk(v == 32'd7, "R1 end flag set", v, 7);
    rd(5'd6, v); chk(v == 32'd0, "R1 count zero", v, 0);
    chk(irq == 4'b0010, "R2 irq raised", 32'(irq), 32'h2);
    chk(bus_req && bus_ch == 2'd2, "R1 exhausted channel stops, next served", 32'(bus_ch), 2);

    wr(5'd7, 32'd3);
    chk(irq == 4'b0000, "R2 irq cleared with end flag", 32'(irq), 0);
    rd(5'd7, v); chk(v == 32'd3, "R9 end flag write-zero clear", v, 3);
    chk(bus_ch == 2'd2, "R8 zero count not eligible", 32'(bus_ch), 2);

    // channel enable clear
    wr(5'd11, 32'd0);
    @(negedge clk);
    chk(bus_req == 1'b0, "R3 request withdrawn", 32'(bus_req), 0);
    rd(5'd10, v); chk(v == 32'd2, "R3 count kept", v, 2);
    rd(5'd11, v); chk(v == 32'd0, "R3 no end flag", v, 0);

    // stop flag
    wr(5'd11, 32'd1);
    @(negedge clk);
    chk(bus_req && bus_ch == 2'd2, "R3 re-enable requests", 32'(bus_req), 1);
    nmi_set = 1'b1;
    @(negedge clk);
    nmi_set = 1'b0;
    @(negedge clk);
    chk(bus_req == 1'b0, "R4 stop withdraws request", 32'(bus_req), 0);
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0, "R4 stays stopped", 32'(bus_req), 0);
    rd(5'd16, v); chk(v == 32'd3, "R4 stop flag visible", v, 3);
    rd(5'd11, v); chk(v == 32'd1, "R4 no end flag", v, 1);
    rd(5'd10, v); chk(v == 32'd2, "R4 count kept", v, 2);
    rd(5'd8, v);  chk(v == 32'h200, "R4 source kept", v, 32'h200);

    // set and clear in the same cycle
    nmi_set = 1'b1; wr_en = 1'b1; wr_addr = 5'd16; wr_data = 32'd1;
    @(posedge clk); @(negedge clk);
    nmi_set = 1'b0; wr_en = 1'b0;
    rd(5'd16, v); chk(v == 32'd3, "R10 set beats clear", v, 3);

    // resume
    wr(5'd16, 32'd1);
    @(negedge clk);
    chk(bus_req && bus_ch == 2'd2 && bus_src == 32'h200, "R11 resume after clear", bus_src, 32'h200);
    beat_once();
    rd(5'd10, v); chk(v == 32'd1, "R6 count after resume", v, 1);
    rd(5'd9, v);  chk(v == 32'h904, "R6 destination after resume", v, 32'h904);

    // master disable
    chk(bus_req == 1'b1, "R13 request pending", 32'(bus_req), 1);
    wr(5'd16, 32'd0);
    @(negedge clk);
    chk(bus_req == 1'b0, "R5 master off withdraws", 32'(bus_req), 0);
    rd(5'd10, v); chk(v == 32'd1, "R5 count kept", v, 1);
    rd(5'd11, v); chk(v == 32'd1, "R5 no end flag", v, 1);

    // enabled channel with zero count
    wr(5'd2, 32'd0); wr(5'd3, 32'd1); wr(5'd16, 32'd1);
    @(negedge clk);
    chk(bus_req && bus_ch == 2'd2, "R8 zero-count channel skipped", 32'(bus_ch), 2);
    beat_once();
    repeat (4) @(negedge clk);
    chk(bus_req == 1'b0, "R8 nothing eligible", 32'(bus_req), 0);
    chk(irq == 4'b0000, "R2 no irq without enable", 32'(irq), 0);
    rd(5'd3, v);  chk(v == 32'd1, "R8 zero count sets no end flag", v, 1);
    rd(5'd11, v); chk(v == 32'd5, "R1 second channel ended", v, 5);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule